// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external SPI controller read and write a bank of 8-bit control registers that lives outside it. The block runs on the chip's system clock. It passes SCLK, MOSI and the active-low chip select through synchronisers and detects their edges in that clock domain. A frame opens with a command byte. Its first bit is the direction (1 = write, 0 = read) and its remaining seven bits are a register pointer. One or three data bytes follow. Data bytes after the first address consecutive registers. The pointer wraps from 127 to 0.

Incoming bits are sampled on rising SCLK edges and MISO changes on falling edges, in SPI mode 0. During each data byte, MISO shifts out the value the addressed register held before the frame began. During the command byte, MISO is zero. Write data is collected in a shadow buffer. It reaches the bank in one system-clock cycle after chip select rises, and only if the frame held exactly 16 or 32 SCLK rising edges. Any other count discards the frame, pulses a framing-error output and sets a sticky error bit. Registers at or above `NUM_REGS` read as zero and never receive a write enable.

The controller is a state machine with these states:
- `ST_IDLE`: waits for chip select to fall, then goes to `ST_CMD`.
- `ST_CMD`: shifts in the command byte. Eight bits go to `ST_FETCH`.
- `ST_FETCH`: spends one cycle reading the bank for the next data byte, then goes to `ST_DATA`.
- `ST_DATA`: shifts a data byte. A completed byte goes to `ST_FETCH` while further bytes remain.
- `ST_COMMIT`: one cycle with write enables raised, then goes to `ST_IDLE`.
- `ST_REJECT`: one cycle with the framing error raised, then goes to `ST_IDLE`.

When chip select rises in `ST_CMD`, `ST_FETCH` or `ST_DATA`, the next state depends on the frame:
- A bad clock count goes to `ST_REJECT`.
- A valid write goes to `ST_COMMIT`.
- A valid read goes to `ST_IDLE`.

From `ST_COMMIT` or `ST_REJECT`, a new falling chip select goes straight to `ST_CMD`.

Top module: `spi_reg_access_slave`

## Requirements
- R1: While chip select is high, `spi_miso` is 0 and no write enable or framing error is raised. All outputs are 0 after reset.
- R2: The first MOSI bit of a frame is the direction (1 = write) and the next seven bits, MSB first, are the pointer. `spi_miso` stays 0 for the whole command byte.
- R3: A write frame of exactly 16 SCLK clocks raises `wr_en[0]` for one cycle after chip select rises. In that cycle `wr_addr[6:0]` holds the pointer and `wr_data[7:0]` holds the data byte.
- R4: A write frame of exactly 32 clocks raises all three write enables in the same single cycle. Lane k (k = 0, 1, 2) is at `wr_addr[7k+6:7k]` and `wr_data[8k+7:8k]`, carrying pointer+k and data byte k.
- R5: During data byte k of a frame, `spi_miso` shifts out, MSB first, the value register pointer+k held before the frame started. It changes on falling SCLK edges and is valid at each rising edge.
- R6: A read frame (direction 0) never raises a write enable, whatever MOSI carries in its data bytes.
- R7: A frame whose clock count at chip-select release is not 16 or 32 writes nothing and raises `frame_err` for exactly one cycle. Counts of 0, 8, 15, 17, 24, 31 and 33 are all rejected.
- R8: `err_sticky` rises in the cycle after `frame_err` and stays high until reset.
- R9: Addresses at or above `NUM_REGS` return 0 on MISO, whatever the bank returns, and their write-enable lanes stay low.
- R10: Consecutive addresses wrap from 127 to 0, for both reads and writes.
- R11: Writes are deferred: no write enable is raised while chip select is low. A 32-bit write therefore reads back the old contents of every register it touches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller, 0 when idle |
| rd_addr | output | ADDR_W | Address of the register to fetch for the current data byte |
| rd_data | input | DATA_W | Combinational read data from the register bank |
| wr_en | output | DATA_BYTES | Per-lane write enables, pulsed for one cycle |
| wr_addr | output | DATA_BYTES*ADDR_W | Packed lane addresses (pointer+k) |
| wr_data | output | DATA_BYTES*DATA_W | Packed lane write data |
| frame_err | output | 1 | One-cycle pulse on a rejected frame |
| err_sticky | output | 1 | Set on any rejected frame, cleared by reset |

## Verification
The bench builds the block with its default parameters: 7-bit pointer, 8-bit data, three data bytes and `NUM_REGS` = 16. It uses a bank model that returns 0xEE for every address outside the implemented range. With only 16 of 128 addresses implemented, single frames can cross the implemented boundary, at 14 to 16 and at 126 through 127 to 0. Leaks of unimplemented data onto MISO and stray write lanes then show up directly. The bench runs the SPI clock at a half period of six system clocks, which leaves the one-cycle fetch ahead of each falling edge with margin. It also drives clock counts around 8, 16, 24, 32 and 40 to reach every accept and reject path.

// File: rtl/spi_ras_pkg.sv
package spi_ras_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_FETCH,
        ST_DATA,
        ST_COMMIT,
        ST_REJECT
    } ras_state_e;

endpackage

// File: rtl/spi_ras_sync.sv
module spi_ras_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[g]}};
            end else begin
                chain <= {chain[STAGES-2:0], din[g]};
            end
        end
        assign dout[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/spi_ras_bit_engine.sv
module spi_ras_bit_engine #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    output logic              frame_start,
    output logic              frame_end,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte,
    output logic [CNT_W-1:0]  bit_count,
    output logic              miso
);

    localparam int              BIT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    logic              sclk_d;
    logic              cs_n_d;
    logic              sclk_rise;
    logic              sclk_fall;
    logic              active;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] tx_q;
    logic [BIT_W-1:0]  bit_in_byte;
    logic              miso_q;

    assign sclk_rise   = sclk_s & ~sclk_d;
    assign sclk_fall   = ~sclk_s & sclk_d;
    assign frame_start = ~cs_n_s & cs_n_d;
    assign frame_end   = cs_n_s & ~cs_n_d;
    assign active      = ~cs_n_s;
    assign rx_byte     = {rx_q[DATA_W-2:0], mosi_s};
    assign byte_done   = active & sclk_rise & (bit_in_byte == LAST_BIT);
    assign miso        = miso_q & active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_n_d <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_n_d <= cs_n_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q        <= '0;
            tx_q        <= '0;
            bit_in_byte <= '0;
            bit_count   <= '0;
            miso_q      <= 1'b0;
        end else if (frame_start) begin
            rx_q        <= '0;
            tx_q        <= '0;
            bit_in_byte <= '0;
            bit_count   <= '0;
            miso_q      <= 1'b0;
        end else if (frame_end) begin
            miso_q <= 1'b0;
        end else if (active) begin
            if (sclk_rise) begin
                rx_q        <= rx_byte;
                bit_in_byte <= (bit_in_byte == LAST_BIT) ? '0 : bit_in_byte + 1'b1;
                if (bit_count != '1) begin
                    bit_count <= bit_count + 1'b1;
                end
            end
            if (tx_load) begin
                tx_q <= tx_data;
            end else if (sclk_fall) begin
                miso_q <= tx_q[DATA_W-1];
                tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/spi_ras_lane_map.sv
module spi_ras_lane_map #(
    parameter int ADDR_W   = 7,
    parameter int LANES    = 3,
    parameter int NUM_REGS = 16
) (
    input  logic [ADDR_W-1:0]       base,
    output logic [LANES*ADDR_W-1:0] lane_addr,
    output logic [LANES-1:0]        lane_impl
);

    localparam logic [ADDR_W:0] NUM_V = (ADDR_W+1)'(NUM_REGS);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [ADDR_W-1:0] addr;
        assign addr                          = base + ADDR_W'(g);
        assign lane_addr[g*ADDR_W +: ADDR_W] = addr;
        assign lane_impl[g]                  = ({1'b0, addr} < NUM_V);
    end

endmodule

// File: rtl/spi_reg_access_slave.sv
module spi_reg_access_slave
    import spi_ras_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int NUM_REGS    = 16,
    parameter int DATA_BYTES  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         spi_sclk,
    input  logic                         spi_cs_n,
    input  logic                         spi_mosi,
    output logic                         spi_miso,
    output logic [ADDR_W-1:0]            rd_addr,
    input  logic [DATA_W-1:0]            rd_data,
    output logic [DATA_BYTES-1:0]        wr_en,
    output logic [DATA_BYTES*ADDR_W-1:0] wr_addr,
    output logic [DATA_BYTES*DATA_W-1:0] wr_data,
    output logic                         frame_err,
    output logic                         err_sticky
);

    localparam int SHORT_BITS = 2 * DATA_W;
    localparam int LONG_BITS  = (DATA_BYTES + 1) * DATA_W;
    localparam int CNT_W      = $clog2(LONG_BITS + 2);
    localparam int IDX_W      = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_BYTES - 1);
    localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(SHORT_BITS);
    localparam logic [CNT_W-1:0] CNT_LONG  = CNT_W'(LONG_BITS);

    logic       sclk_s, cs_n_s, mosi_s;
    logic       frame_start, frame_end, byte_done;
    logic [DATA_W-1:0] rx_byte;
    logic [CNT_W-1:0]  bit_count;
    logic       tx_load;
    logic [DATA_W-1:0] tx_data;

    ras_state_e state_q, state_d, end_state;

    logic                               dir_q;
    logic [ADDR_W-1:0]                  ptr_q;
    logic [IDX_W-1:0]                   idx_q;
    logic                               long_q;
    logic [DATA_BYTES-1:0][DATA_W-1:0]  shadow_q;
    logic [DATA_BYTES-1:0]              lane_impl;
    logic                               rd_impl;
    logic                               frame_ok;
    logic                               frame_long;

    spi_ras_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_mosi, spi_cs_n, spi_sclk}),
        .dout  ({mosi_s, cs_n_s, sclk_s})
    );

    spi_ras_bit_engine #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (sclk_s),
        .cs_n_s      (cs_n_s),
        .mosi_s      (mosi_s),
        .tx_load     (tx_load),
        .tx_data     (tx_data),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .byte_done   (byte_done),
        .rx_byte     (rx_byte),
        .bit_count   (bit_count),
        .miso        (spi_miso)
    );

    spi_ras_lane_map #(
        .ADDR_W   (ADDR_W),
        .LANES    (DATA_BYTES),
        .NUM_REGS (NUM_REGS)
    ) u_lanes (
        .base      (ptr_q),
        .lane_addr (wr_addr),
        .lane_impl (lane_impl)
    );

    // Read lane chosen by the current data-byte index
    always_comb begin
        rd_addr = wr_addr[ADDR_W-1:0];
        rd_impl = lane_impl[0];
        for (int i = 1; i < DATA_BYTES; i++) begin
            if (idx_q == IDX_W'(i)) begin
                rd_addr = wr_addr[i*ADDR_W +: ADDR_W];
                rd_impl = lane_impl[i];
            end
        end
    end

    assign tx_load    = (state_q == ST_FETCH);
    assign tx_data    = rd_impl ? rd_data : '0;
    assign frame_ok   = (bit_count == CNT_SHORT) || (bit_count == CNT_LONG);
    assign frame_long = (bit_count == CNT_LONG);
    assign wr_data    = shadow_q;

    // Where a frame goes when chip select is released
    always_comb begin
        if (!frame_ok) begin
            end_state = ST_REJECT;
        end else if (dir_q) begin
            end_state = ST_COMMIT;
        end else begin
            end_state = ST_IDLE;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (frame_start) state_d = ST_CMD;
            end
            ST_CMD: begin
                if (frame_end)      state_d = end_state;
                else if (byte_done) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (frame_end) state_d = end_state;
                else           state_d = ST_DATA;
            end
            ST_DATA: begin
                if (frame_end)                          state_d = end_state;
                else if (byte_done && idx_q < IDX_LAST) state_d = ST_FETCH;
            end
            ST_COMMIT, ST_REJECT: begin
                state_d = frame_start ? ST_CMD : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Frame datapath: command capture, shadow buffer, frame length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q    <= 1'b0;
            ptr_q    <= '0;
            idx_q    <= '0;
            long_q   <= 1'b0;
            shadow_q <= '0;
        end else begin
            if (frame_start) begin
                idx_q  <= '0;
                long_q <= 1'b0;
            end
            if (state_q == ST_CMD && byte_done && !frame_end) begin
                dir_q <= rx_byte[DATA_W-1];
                ptr_q <= rx_byte[ADDR_W-1:0];
            end
            if (state_q == ST_DATA && byte_done && !frame_end) begin
                shadow_q[idx_q] <= rx_byte;
                if (idx_q < IDX_LAST) idx_q <= idx_q + 1'b1;
            end
            if (frame_end) begin
                long_q <= frame_long;
            end
        end
    end

    // Outputs from state
    always_comb begin
        wr_en     = '0;
        frame_err = 1'b0;
        unique case (state_q)
            ST_COMMIT: begin
                for (int i = 0; i < DATA_BYTES; i++) begin
                    wr_en[i] = lane_impl[i] && (i == 0 || long_q);
                end
            end
            ST_REJECT: frame_err = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    err_sticky <= 1'b0;
        else if (state_q == ST_REJECT) err_sticky <= 1'b1;
    end

endmodule

// File: rtl/spi_reg_access_slave_chk.sv
module spi_reg_access_slave_chk #(
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16,
    parameter int LANES    = 3,
    parameter int CNT_W    = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    spi_cs_n,
    input logic                    cs_n_s,
    input logic                    spi_miso,
    input logic [CNT_W-1:0]        bit_count,
    input logic [LANES-1:0]        wr_en,
    input logic [LANES*ADDR_W-1:0] wr_addr,
    input logic                    frame_err,
    input logic                    err_sticky
);

    localparam logic [ADDR_W:0]  NUM_V    = (ADDR_W+1)'(NUM_REGS);
    localparam logic [CNT_W-1:0] CMD_BITS = CNT_W'(DATA_W);

    a_r1_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso);

    a_r2_cmd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && bit_count < CMD_BITS) |-> !spi_miso);

    a_r3_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_en) |=> (wr_en == '0));

    a_r7_no_write_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> (wr_en == '0));

    a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    a_r8_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> err_sticky);

    a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    a_r11_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_en) |-> cs_n_s);

    for (genvar g = 0; g < LANES; g++) begin : g_impl
        a_r9_impl_only: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[g] |-> ({1'b0, wr_addr[g*ADDR_W +: ADDR_W]} < NUM_V));
    end

endmodule

bind spi_reg_access_slave spi_reg_access_slave_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .LANES    (DATA_BYTES),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_cs_n   (spi_cs_n),
    .cs_n_s     (cs_n_s),
    .spi_miso   (spi_miso),
    .bit_count  (bit_count),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .frame_err  (frame_err),
    .err_sticky (err_sticky)
);

// File: tb/tb_spi_reg_access_slave.sv
module tb_spi_reg_access_slave;

    localparam int NUM_REGS = 16;
    localparam int H        = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [6:0]  rd_addr;
    logic [7:0]  rd_data;
    logic [2:0]  wr_en;
    logic [20:0] wr_addr;
    logic [23:0] wr_data;
    logic        frame_err;
    logic        err_sticky;

    logic [7:0] bank    [0:127];
    logic [7:0] exp_mem [0:127];

    int  n_checks    = 0;
    int  n_fail      = 0;
    int  err_pulses  = 0;
    int  early_wr    = 0;
    int  exp_pulses  = 0;
    bit  exp_sticky  = 1'b0;
    bit  done        = 1'b0;

    always #5 clk = ~clk;

    spi_reg_access_slave dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sclk   (sclk),
        .spi_cs_n   (cs_n),
        .spi_mosi   (mosi),
        .spi_miso   (miso),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_err  (frame_err),
        .err_sticky (err_sticky)
    );

    assign rd_data = bank[rd_addr];

    always @(posedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (wr_en[i]) bank[wr_addr[i*7 +: 7]] <= wr_data[i*8 +: 8];
        end
        if (rst_n) begin
            if (frame_err) err_pulses <= err_pulses + 1;
            if (|wr_en && !cs_n) early_wr <= early_wr + 1;
        end
    end

    function automatic logic [7:0] rdval(input logic [6:0] a);
        return (int'(a) < NUM_REGS) ? exp_mem[a] : 8'h00;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    task automatic do_frame(input logic dir, input logic [6:0] ptr, input int nclk,
                            input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                            input string req);
        logic [31:0] tx;
        logic [31:0] got;
        logic [31:0] exp_miso;
        logic [31:0] mask;
        bit          valid;
        int          nbytes;
        int          bad;
        int          bad_a;
        tx       = {dir, ptr, d0, d1, d2};
        got      = '0;
        exp_miso = {8'h00, rdval(ptr), rdval(ptr + 7'd1), rdval(ptr + 7'd2)};
        mask     = (nclk >= 32) ? 32'hFFFF_FFFF : ~(32'hFFFF_FFFF >> nclk);
        valid    = (nclk == 16) || (nclk == 32);
        nbytes   = (nclk == 32) ? 3 : 1;

        @(negedge clk) cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            mosi = (i < 32) ? tx[31-i] : 1'b0;
            repeat (H) @(negedge clk);
            if (i < 32) got[31-i] = miso;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
        mosi = 1'b0;
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);

        // R2 command byte zeros, R5 old register contents on data bytes
        chk((got & mask) == (exp_miso & mask), {req, " R5 miso"}, 64'(got & mask), 64'(exp_miso & mask));

        if (valid && dir) begin
            for (int k = 0; k < nbytes; k++) begin
                logic [6:0] a;
                a = ptr + 7'(k);
                if (int'(a) < NUM_REGS) exp_mem[a] = (k == 0) ? d0 : (k == 1) ? d1 : d2;
            end
        end
        if (!valid) begin
            exp_pulses++;
            exp_sticky = 1'b1;
        end

        bad = 0;
        bad_a = 0;
        for (int a = 0; a < 128; a++) begin
            if (bank[a] !== exp_mem[a]) begin
                if (bad == 0) bad_a = a;
                bad++;
            end
        end
        chk(bad == 0, {req, " bank contents"}, 64'({bad_a[7:0], bank[bad_a]}), 64'({bad_a[7:0], exp_mem[bad_a]}));
        chk(err_pulses == exp_pulses, "R7 frame_err pulses", 64'(err_pulses), 64'(exp_pulses));
        chk(err_sticky == exp_sticky, "R8 err_sticky", 64'(err_sticky), 64'(exp_sticky));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0001));
        for (int a = 0; a < 128; a++) begin
            bank[a]    = (a < NUM_REGS) ? 8'($urandom) : 8'hEE;
            exp_mem[a] = bank[a];
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk(miso == 1'b0 && wr_en == 3'b000 && frame_err == 1'b0 && err_sticky == 1'b0,
            "R1 reset outputs", 64'({miso, wr_en, frame_err, err_sticky}), 64'd0);

        do_frame(1'b1, 7'd3, 16, 8'hA5, 8'h00, 8'h00, "R3");
        do_frame(1'b0, 7'd3, 16, 8'h5A, 8'h00, 8'h00, "R6");
        do_frame(1'b1, 7'd14, 32, 8'h11, 8'h22, 8'h33, "R9");
        do_frame(1'b1, 7'd126, 32, 8'h44, 8'h55, 8'h66, "R10");
        do_frame(1'b0, 7'd127, 32, 8'hFF, 8'hFF, 8'hFF, "R10");
        do_frame(1'b1, 7'd4, 32, 8'h01, 8'h02, 8'h03, "R4");
        do_frame(1'b1, 7'd4, 32, 8'h0A, 8'h0B, 8'h0C, "R11");
        do_frame(1'b0, 7'd5, 32, 8'hC3, 8'h3C, 8'h99, "R6");
        do_frame(1'b1, 7'd20, 16, 8'h77, 8'h00, 8'h00, "R9");
        do_frame(1'b1, 7'd1, 15, 8'h12, 8'h34, 8'h56, "R7");
        do_frame(1'b1, 7'd1, 17, 8'h12, 8'h34, 8'h56, "R7");
        do_frame(1'b1, 7'd1, 31, 8'h12, 8'h34, 8'h56, "R7");
        do_frame(1'b1, 7'd1, 33, 8'h12, 8'h34, 8'h56, "R7");
        do_frame(1'b1, 7'd1, 0, 8'h12, 8'h34, 8'h56, "R7");
        do_frame(1'b1, 7'd1, 8, 8'h12, 8'h34, 8'h56, "R7");
        do_frame(1'b1, 7'd1, 24, 8'h12, 8'h34, 8'h56, "R7");
        do_frame(1'b1, 7'd1, 16, 8'h9C, 8'h00, 8'h00, "R3");

        for (int n = 0; n < 110; n++) begin
            logic [6:0] p;
            int         r;
            int         nc;
            logic       d;
            string      tag;
            d = 1'($urandom);
            r = int'($urandom % 4);
            if (r == 0)      p = 7'(125 + $urandom % 3);
            else if (r == 1) p = 7'($urandom);
            else             p = 7'($urandom % (NUM_REGS + 2));
            r = int'($urandom % 10);
            if (r < 4)      nc = 16;
            else if (r < 8) nc = 32;
            else            nc = int'($urandom % 41);
            if (nc != 16 && nc != 32) tag = "R7";
            else if (!d)              tag = "R6";
            else if (nc == 32)        tag = "R4";
            else                      tag = "R3";
            do_frame(d, p, nc, 8'($urandom), 8'($urandom), 8'($urandom), tag);
        end

        // R11 no write enable while chip select low; R1 idle outputs
        chk(early_wr == 0, "R11 write while selected", 64'(early_wr), 64'd0);
        chk(miso == 1'b0 && wr_en == 3'b000, "R1 idle outputs", 64'({miso, wr_en}), 64'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule